// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Unit

This block is the per-pin interrupt detector that follows a pin's debounce filter. It watches the filtered pin level and, according to the pin's configuration, detects either an edge or an active level. When it sees one it sets two sticky status flags: the interrupt status and, if waking from the current power state is allowed, the wake status. The block offers an OR of the two flags to the interrupt summary logic as a pending request.

Software configures the trigger through plain register fields. A trigger-mode bit selects edge or level sensing, and a 2-bit polarity code selects the edge or level. An enable bit decides whether events are captured at all. A separate unmask bit only decides whether a captured status reaches the summary logic. Each status flag has a write-one-to-clear strobe. The enable reads back as clear until the debounce filter reports that its warm-up is over, and events are not captured during that time.

Top module: `pin_irq_trigger`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, int_sts, wake_sts and pending are 0, whatever the other inputs are.
- R2: In edge mode (cfg_level_mode = 0) with cfg_polarity = 2'b00, a low-to-high change of pin_lvl sets int_sts at the next clock edge. The flag stays set after the pin returns low.
- R3: In edge mode with cfg_polarity = 2'b01, only a high-to-low change of pin_lvl sets int_sts. A rising change does not.
- R4: In edge mode with cfg_polarity = 2'b10, either change of pin_lvl sets int_sts.
- R5: In level mode (cfg_level_mode = 1), cfg_polarity = 2'b00 sets int_sts on every cycle that pin_lvl is 1, and 2'b01 on every cycle that it is 0. The flag stays set after the level goes away. A clear while the level is still active is overridden, so the flag stays set.
- R6: cfg_polarity = 2'b11 in either mode, and 2'b10 in level mode, never set int_sts.
- R7: int_en_rd is 1 only when cfg_int_en and warm_done are both 1. Events that occur while int_en_rd is 0 are not captured into either status flag.
- R8: pending equals (int_sts OR wake_sts) AND cfg_int_unmask. cfg_int_unmask has no effect on whether status is captured.
- R9: wake_sts sets on the same event that sets int_sts, but only when bit pwr_state of cfg_wake_en is 1. A pwr_state of NUM_PWR_STATES or above never sets it.
- R10: A 1 on clr_int_sts or clr_wake_sts clears only its own flag at the next clock edge. A new event in the same cycle wins over the clear.
- R11: No edge is reported on the first clock edge after reset. At that point there is no earlier pin sample, so a pin that is already high does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 1 | Debounced pin level |
| cfg_level_mode | input | 1 | 1 = level sensing, 0 = edge sensing |
| cfg_polarity | input | 2 | 00 high/rising, 01 low/falling, 10 both edges, 11 none |
| cfg_int_en | input | 1 | Capture enable |
| cfg_int_unmask | input | 1 | 1 = deliver pending status |
| cfg_wake_en | input | NUM_PWR_STATES | Wake enable per power state |
| pwr_state | input | PWR_W | Current power state index |
| warm_done | input | 1 | Debounce warm-up complete |
| clr_int_sts | input | 1 | Write-one-to-clear strobe for int_sts |
| clr_wake_sts | input | 1 | Write-one-to-clear strobe for wake_sts |
| int_en_rd | output | 1 | Enable as read back (gated by warm-up) |
| int_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| pending | output | 1 | Request to the interrupt summary logic |

## Verification
On every cycle the assertions check four things. A status flag stays set until it is cleared. A clear with no competing event takes effect. A flag never rises unless capture was enabled and, for the wake flag, unless the power state allowed it. Invalid polarity codes in level mode never raise the interrupt flag. The bench scenarios cover what needs a chosen history to show: the direction of each edge, level re-assertion through a clear, the missing pin history just after reset, the effect of the mask on delivery, and the enable readback held low during warm-up.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
package pin_irq_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef enum logic [1:0] {
        POL_HIGH_RISE = 2'b00,
        POL_LOW_FALL  = 2'b01,
        POL_ANY_EDGE  = 2'b10,
        POL_NONE      = 2'b11
    } pol_e;

    // Observations of the pin over one clock step
    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic low;
    } pin_obs_t;

    localparam int STS_INT  = 0;
    localparam int STS_WAKE = 1;
    localparam int NUM_STS  = 2;

    function automatic logic trig_hit(trig_e mode, pol_e pol, pin_obs_t obs);
        logic hit;
        hit = 1'b0;
        if (mode == TRIG_EDGE) begin
            case (pol)
                POL_HIGH_RISE: hit = obs.rise;
                POL_LOW_FALL:  hit = obs.fall;
                POL_ANY_EDGE:  hit = obs.rise | obs.fall;
                default:       hit = 1'b0;
            endcase
        end else begin
            case (pol)
                POL_HIGH_RISE: hit = obs.high;
                POL_LOW_FALL:  hit = obs.low;
                default:       hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/pin_evt_detect.sv
`timescale 1ns/1ps
module pin_evt_detect
    import pin_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_lvl,
    input  trig_e trig_mode,
    input  pol_e  polarity,
    output logic  evt
);

    logic     pin_q;
    logic     hist_ok;
    pin_obs_t obs;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= 1'b0;
            hist_ok <= 1'b0;
        end else begin
            pin_q   <= pin_lvl;
            hist_ok <= 1'b1;
        end
    end

    always_comb begin
        obs.rise = hist_ok & pin_lvl & ~pin_q;
        obs.fall = hist_ok & ~pin_lvl & pin_q;
        obs.high = pin_lvl;
        obs.low  = ~pin_lvl;
    end

    assign evt = trig_hit(trig_mode, polarity, obs);

    // R11
    first_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!hist_ok && trig_mode == TRIG_EDGE) |-> !evt);

endmodule

// File: rtl/pin_irq_gate.sv
`timescale 1ns/1ps
module pin_irq_gate #(
    parameter int NUM_PWR_STATES = 3,
    parameter int PWR_W = (NUM_PWR_STATES > 1) ? $clog2(NUM_PWR_STATES) : 1
) (
    input  logic                      int_en,
    input  logic                      warm_done,
    input  logic [NUM_PWR_STATES-1:0] wake_en,
    input  logic [PWR_W-1:0]          pwr_state,
    output logic                      en_eff,
    output logic                      wake_ok
);

    logic [NUM_PWR_STATES-1:0] state_hit;

    for (genvar g = 0; g < NUM_PWR_STATES; g++) begin : g_state
        assign state_hit[g] = (pwr_state == PWR_W'(g)) & wake_en[g];
    end

    assign wake_ok = |state_hit;
    assign en_eff  = int_en & warm_done;

endmodule

// File: rtl/pin_irq_status.sv
`timescale 1ns/1ps
module pin_irq_status
    import pin_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_STS-1:0] set_v,
    input  logic [NUM_STS-1:0] clr_v,
    output logic [NUM_STS-1:0] sts
);

    for (genvar b = 0; b < NUM_STS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           sts[b] <= 1'b0;
            else if (set_v[b]) sts[b] <= 1'b1;
            else if (clr_v[b]) sts[b] <= 1'b0;
        end

        // R10
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (sts[b] && !clr_v[b]) |=> sts[b]);

        // R10
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_v[b] && !set_v[b]) |=> !sts[b]);
    end

endmodule

// File: rtl/pin_irq_trigger.sv
`timescale 1ns/1ps
module pin_irq_trigger
    import pin_irq_pkg::*;
#(
    parameter int NUM_PWR_STATES = 3,
    localparam int PWR_W = (NUM_PWR_STATES > 1) ? $clog2(NUM_PWR_STATES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pin_lvl,
    input  logic                      cfg_level_mode,
    input  logic [1:0]                cfg_polarity,
    input  logic                      cfg_int_en,
    input  logic                      cfg_int_unmask,
    input  logic [NUM_PWR_STATES-1:0] cfg_wake_en,
    input  logic [PWR_W-1:0]          pwr_state,
    input  logic                      warm_done,
    input  logic                      clr_int_sts,
    input  logic                      clr_wake_sts,
    output logic                      int_en_rd,
    output logic                      int_sts,
    output logic                      wake_sts,
    output logic                      pending
);

    logic               evt;
    logic               en_eff;
    logic               wake_ok;
    logic [NUM_STS-1:0] set_v;
    logic [NUM_STS-1:0] clr_v;
    logic [NUM_STS-1:0] sts;

    pin_evt_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .pin_lvl   (pin_lvl),
        .trig_mode (trig_e'(cfg_level_mode)),
        .polarity  (pol_e'(cfg_polarity)),
        .evt       (evt)
    );

    pin_irq_gate #(
        .NUM_PWR_STATES (NUM_PWR_STATES),
        .PWR_W          (PWR_W)
    ) u_gate (
        .int_en    (cfg_int_en),
        .warm_done (warm_done),
        .wake_en   (cfg_wake_en),
        .pwr_state (pwr_state),
        .en_eff    (en_eff),
        .wake_ok   (wake_ok)
    );

    always_comb begin
        set_v           = '0;
        set_v[STS_INT]  = evt & en_eff;
        set_v[STS_WAKE] = evt & en_eff & wake_ok;
        clr_v           = '0;
        clr_v[STS_INT]  = clr_int_sts;
        clr_v[STS_WAKE] = clr_wake_sts;
    end

    pin_irq_status u_status (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .sts   (sts)
    );

    assign int_sts   = sts[STS_INT];
    assign wake_sts  = sts[STS_WAKE];
    assign int_en_rd = en_eff;
    assign pending   = (int_sts | wake_sts) & cfg_int_unmask;

    // R7
    capture_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_sts) |-> $past(int_en_rd));

    // R9
    wake_needs_state_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_sts) |-> ($past(wake_ok) && int_sts));

    // R6
    level_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_level_mode && cfg_polarity[1] && !int_sts) |=> !int_sts);

endmodule

// File: tb/pin_irq_trigger_bench.sv
`timescale 1ns/1ps
module pin_irq_trigger_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin_lvl, cfg_level_mode, cfg_int_en, cfg_int_unmask;
    logic [1:0] cfg_polarity;
    logic [2:0] cfg_wake_en;
    logic [1:0] pwr_state;
    logic       warm_done, clr_int_sts, clr_wake_sts;
    logic       int_en_rd, int_sts, wake_sts, pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pin_irq_trigger u_pin_irq_trigger (
        .clk (clk), .rst (rst), .pin_lvl (pin_lvl),
        .cfg_level_mode (cfg_level_mode), .cfg_polarity (cfg_polarity),
        .cfg_int_en (cfg_int_en), .cfg_int_unmask (cfg_int_unmask),
        .cfg_wake_en (cfg_wake_en), .pwr_state (pwr_state),
        .warm_done (warm_done), .clr_int_sts (clr_int_sts),
        .clr_wake_sts (clr_wake_sts), .int_en_rd (int_en_rd),
        .int_sts (int_sts), .wake_sts (wake_sts), .pending (pending)
    );

    typedef struct packed {
        logic       pin;
        logic       lm;
        logic [1:0] pol;
        logic       en;
        logic       wd;
        logic       um;
        logic [2:0] wk;
        logic [1:0] ps;
        logic       ci;
        logic       cw;
        logic       e_int;
        logic       e_wake;
        logic       e_pend;
        logic       e_enrd;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 46;
    // pin lm pol en wd um wk ps ci cw | int wake pend enrd | req
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},  // R2 fall ignored
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd2},  // R2 rise sets
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd2},  // R2 held
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10 clear
        '{1'b0,1'b0,2'b01,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3
        '{1'b1,1'b0,2'b01,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd3},  // R3 rise ignored
        '{1'b0,1'b0,2'b01,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd3},  // R3 fall sets
        '{1'b0,1'b0,2'b01,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10
        '{1'b1,1'b0,2'b10,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd4},  // R4 rise
        '{1'b1,1'b0,2'b10,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd4},  // R4 no edge
        '{1'b0,1'b0,2'b10,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd4},  // R4 fall
        '{1'b0,1'b0,2'b10,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10
        '{1'b1,1'b0,2'b11,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 edge 11
        '{1'b0,1'b0,2'b11,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 edge 11
        '{1'b0,1'b1,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5 inactive
        '{1'b1,1'b1,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd5},  // R5 high
        '{1'b1,1'b1,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd10}, // R10 set wins
        '{1'b0,1'b1,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd5},  // R5 sticky
        '{1'b0,1'b1,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5 cleared
        '{1'b0,1'b1,2'b01,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd5},  // R5 low
        '{1'b1,1'b1,2'b01,1'b1,1'b1,1'b1,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd5},  // R5
        '{1'b1,1'b1,2'b10,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 level 10
        '{1'b0,1'b1,2'b10,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 level 10
        '{1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd6},  // R6 level 11
        '{1'b0,1'b0,2'b00,1'b0,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 en off
        '{1'b1,1'b0,2'b00,1'b0,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 rise ignored
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 warm-up
        '{1'b1,1'b0,2'b00,1'b1,1'b0,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 warm-up rise
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd7},  // R7 armed
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b0,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1, 4'd8},  // R8 masked
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b000,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd8},  // R8 unmasked
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b0,3'b000,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd8},  // R8
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd9},  // R9
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1, 4'd9},  // R9 wake sets
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b1, 4'd10}, // R10 own bit
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd2,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd9},  // R9
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd2,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd9},  // R9 state off
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b0,3'b010,2'd2,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1, 4'd8},  // R8
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b111,2'd3,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd9},  // R9 state 3
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b111,2'd3,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd9},  // R9
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b111,2'd3,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd9},  // R9 out of range
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10
        '{1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd9},  // R9
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b1, 4'd8},  // R8 set over clear
        '{1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,3'b010,2'd1,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b1, 4'd8}   // R8 wake-only pending
    };

    task automatic check(input int req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: {int,wake,pend,en_rd} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {int_sts, wake_sts, pending, int_en_rd};
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pin_lvl = 1'b0; cfg_level_mode = 1'b0; cfg_polarity = 2'b00;
        cfg_int_en = 1'b0; cfg_int_unmask = 1'b0; cfg_wake_en = 3'b000;
        pwr_state = 2'd0; warm_done = 1'b0; clr_int_sts = 1'b0; clr_wake_sts = 1'b0;
        repeat (3) @(negedge clk);
        // R1: inputs that would set status while reset holds
        pin_lvl = 1'b1; cfg_int_en = 1'b1; warm_done = 1'b1; cfg_int_unmask = 1'b1;
        cfg_level_mode = 1'b1; cfg_wake_en = 3'b001;
        @(negedge clk);
        check(1, {int_sts, wake_sts, pending}, 3'b000);  // R1
        // R11: release reset with pin already high in rising-edge mode
        cfg_level_mode = 1'b0; rst = 1'b0; cfg_wake_en = 3'b000;
        @(negedge clk);
        check(11, outs(), 4'b0001);                       // R11
        @(negedge clk);
        check(11, outs(), 4'b0001);                       // R11 steady high
        for (int i = 0; i < NV; i++) begin
            pin_lvl        = VECS[i].pin;
            cfg_level_mode = VECS[i].lm;
            cfg_polarity   = VECS[i].pol;
            cfg_int_en     = VECS[i].en;
            warm_done      = VECS[i].wd;
            cfg_int_unmask = VECS[i].um;
            cfg_wake_en    = VECS[i].wk;
            pwr_state      = VECS[i].ps;
            clr_int_sts    = VECS[i].ci;
            clr_wake_sts   = VECS[i].cw;
            @(negedge clk);
            check(int'(VECS[i].tag), outs(),
                  {VECS[i].e_int, VECS[i].e_wake, VECS[i].e_pend, VECS[i].e_enrd});
        end
        clr_int_sts = 1'b0; clr_wake_sts = 1'b0;
        // R1: reset mid-run clears set flags
        rst = 1'b1;
        @(negedge clk);
        check(1, {int_sts, wake_sts, pending}, 3'b000);   // R1
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule